// File: doc/BRIEF.md
# Byte/Word Unary and Logic Operation Unit

This block is the single-operand and bitwise section of a small 16-bit microcontroller datapath. Each strobed request carries an operation code, a size select, a destination operand and a source operand. The unit performs one of ten operations:

- sign extension and zero extension of a byte to a word;
- compare against zero;
- two's complement negate;
- clear;
- test-and-set of the byte's top bit;
- bitwise AND, OR and XOR;
- one's complement.

It returns the new destination value, a write-back enable and the N and Z condition flags, all registered on the clock edge after the strobe.

In byte size only the low eight bits are processed, and the upper byte of the destination passes through to the result untouched. The extend operations are the exception: they rewrite the upper byte by definition. A request that has no meaning raises a one-cycle error pulse instead of writing anything. Examples are an undefined code, or word size with an operation that exists only for bytes.

Top module: `bw_unary_alu`

## Requirements
- R1: A synchronous active-high reset clears the result register, the write enable, both flags and the error output to 0 on the next clock edge.
- R2: All outputs change only on the clock edge that samples `in_vld` high. In a cycle after an edge where `in_vld` was low, `res_we` and `err` are 0, and `res_q`, `flag_n` and `flag_z` keep their values.
- R3: Code 0 (sign extend, byte size only) produces a result whose bits 15..8 are all copies of operand bit 7 and whose bits 7..0 equal the operand's low byte, with `res_we` = 1.
- R4: Code 1 (zero extend, byte size only) produces a result whose bits 15..8 are 0 and whose bits 7..0 equal the operand's low byte, with `res_we` = 1.
- R5: Code 2 (test) updates the flags from the destination operand in the selected size. It gives `res_we` = 0 and leaves `res_q` unchanged.
- R6: Code 3 (negate) produces 0 minus the operand, modulo 2^8 in byte size or 2^16 in word size, with `res_we` = 1.
- R7: Code 4 (clear) produces 0 in the sized part of the result, with `res_we` = 1.
- R8: Code 5 (test-and-set, byte size only) computes the flags from the operand before modification. Its result is the operand with bit 7 forced to 1, with `res_we` = 1.
- R9: Codes 6, 7 and 8 produce the bitwise AND, OR and XOR of destination and source, with `res_we` = 1.
- R10: Code 9 produces the bitwise inversion of the destination, with `res_we` = 1.
- R11: `in_word` = 0 selects byte size and 1 selects word size. In byte size, codes 2 to 9 leave result bits 15..8 equal to destination bits 15..8.
- R12: `flag_n` is bit 7 (byte) or bit 15 (word) of the flag source, and `flag_z` is 1 when the sized flag source is all zero. The flag source is the operand for codes 2 and 5 and the result for the other codes. Codes 0 and 1 use byte size for their flags.
- R13: Codes 10 to 15, and word size with codes 0, 1 or 5, are illegal. An illegal request gives `res_we` = 0 and `err` = 1 for one cycle, and leaves `res_q`, `flag_n` and `flag_z` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request strobe |
| in_op | input | 4 | Operation code |
| in_word | input | 1 | Size select, 1 = word, 0 = byte |
| dst_in | input | 16 | Destination operand |
| src_in | input | 16 | Source operand for AND/OR/XOR |
| res_q | output | 16 | Registered result |
| res_we | output | 1 | Write-back enable for the result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| err | output | 1 | Illegal request pulse |

## Verification
All results, the write enable, the flags and the error pulse are due exactly one clock edge after the edge that samples the strobe. The bench therefore drives a request on a falling edge and samples the outputs on the following falling edge. It then drops the strobe for one cycle and samples again. That second sample confirms the write enable and error have returned to 0 and the result and flags were held. A bench model carries the held result and flags across requests, so the no-write and illegal cases are checked against whatever the previous request left behind.

// File: rtl/bwalu_pkg.sv
package bwalu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SEXT = 4'd0,
    OP_ZEXT = 4'd1,
    OP_TEST = 4'd2,
    OP_NEG  = 4'd3,
    OP_CLR  = 4'd4,
    OP_TSET = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_NOT  = 4'd9
  } op_e;

  localparam logic [OP_W-1:0] OP_LAST = 4'd9;

  typedef struct packed {
    logic legal;
    logic wb;
    logic flag_from_opnd;
    logic full_width;
    logic flag_word;
  } ctl_t;
endpackage

// File: rtl/bwalu_decode.sv
module bwalu_decode
  import bwalu_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            word,
  output ctl_t            ctl
);
  logic known;
  logic byte_only;

  always_comb begin
    known     = (op <= OP_LAST);
    byte_only = (op == OP_SEXT) || (op == OP_ZEXT) || (op == OP_TSET);
    ctl.legal = known && !(word && byte_only);
    ctl.wb    = ctl.legal && (op != OP_TEST);
    ctl.flag_from_opnd = (op == OP_TEST) || (op == OP_TSET);
    ctl.full_width     = (op == OP_SEXT) || (op == OP_ZEXT) || word;
    ctl.flag_word      = word && !byte_only;
  end
endmodule

// File: rtl/bwalu_compute.sv
module bwalu_compute
  import bwalu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LO_W   = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic              full_width,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] result
);
  localparam int HI_W = DATA_W - LO_W;

  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] keep_mask;

  always_comb begin
    case (op)
      OP_SEXT: raw = {{HI_W{dst[LO_W-1]}}, dst[LO_W-1:0]};
      OP_ZEXT: raw = {{HI_W{1'b0}}, dst[LO_W-1:0]};
      OP_NEG:  raw = {DATA_W{1'b0}} - dst;
      OP_CLR:  raw = '0;
      OP_TSET: raw = dst | (DATA_W'(1) << (LO_W - 1));
      OP_AND:  raw = dst & src;
      OP_OR:   raw = dst | src;
      OP_XOR:  raw = dst ^ src;
      OP_NOT:  raw = ~dst;
      default: raw = dst;
    endcase
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    if (i < LO_W) begin : g_lo
      assign keep_mask[i] = 1'b0;
    end else begin : g_hi
      assign keep_mask[i] = !full_width;
    end
  end

  assign result = (raw & ~keep_mask) | (dst & keep_mask);
endmodule

// File: rtl/bwalu_flags.sv
module bwalu_flags #(
  parameter int DATA_W = 16,
  parameter int LO_W   = 8
) (
  input  logic [DATA_W-1:0] value,
  input  logic              word,
  output logic              neg,
  output logic              zero
);
  always_comb begin
    if (word) begin
      neg  = value[DATA_W-1];
      zero = (value == '0);
    end else begin
      neg  = value[LO_W-1];
      zero = (value[LO_W-1:0] == '0);
    end
  end
endmodule

// File: rtl/bwalu_out_stage.sv
module bwalu_out_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld,
  input  logic              legal,
  input  logic              wb,
  input  logic [DATA_W-1:0] res_d,
  input  logic              n_d,
  input  logic              z_d,
  output logic [DATA_W-1:0] res_q,
  output logic              we_q,
  output logic              n_q,
  output logic              z_q,
  output logic              err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      we_q  <= 1'b0;
      n_q   <= 1'b0;
      z_q   <= 1'b0;
      err_q <= 1'b0;
    end else if (vld) begin
      we_q  <= wb;
      err_q <= !legal;
      if (legal) begin
        n_q <= n_d;
        z_q <= z_d;
      end
      if (wb) res_q <= res_d;
    end else begin
      we_q  <= 1'b0;
      err_q <= 1'b0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(vld) |-> (!we_q && !err_q)); // R2
  AST_WE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(we_q && err_q)); // R13
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    err_q |-> ($stable(n_q) && $stable(z_q) && $stable(res_q))); // R13
endmodule

// File: rtl/bw_unary_alu.sv
module bw_unary_alu
  import bwalu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LO_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [OP_W-1:0]   in_op,
  input  logic              in_word,
  input  logic [DATA_W-1:0] dst_in,
  input  logic [DATA_W-1:0] src_in,
  output logic [DATA_W-1:0] res_q,
  output logic              res_we,
  output logic              flag_n,
  output logic              flag_z,
  output logic              err
);
  ctl_t              ctl;
  logic [DATA_W-1:0] result;
  logic [DATA_W-1:0] flag_src;
  logic              n_d;
  logic              z_d;

  bwalu_decode u_decode (
    .op   (in_op),
    .word (in_word),
    .ctl  (ctl)
  );

  bwalu_compute #(.DATA_W(DATA_W), .LO_W(LO_W)) u_compute (
    .op         (in_op),
    .full_width (ctl.full_width),
    .dst        (dst_in),
    .src        (src_in),
    .result     (result)
  );

  assign flag_src = ctl.flag_from_opnd ? dst_in : result;

  bwalu_flags #(.DATA_W(DATA_W), .LO_W(LO_W)) u_flags (
    .value (flag_src),
    .word  (ctl.flag_word),
    .neg   (n_d),
    .zero  (z_d)
  );

  bwalu_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .vld   (in_vld),
    .legal (ctl.legal),
    .wb    (ctl.wb),
    .res_d (result),
    .n_d   (n_d),
    .z_d   (z_d),
    .res_q (res_q),
    .we_q  (res_we),
    .n_q   (flag_n),
    .z_q   (flag_z),
    .err_q (err)
  );

  AST_TEST_NO_WB: assert property (@(posedge clk) disable iff (rst)
    $past(in_vld && (in_op == OP_TEST)) |-> (!res_we && $stable(res_q))); // R5
  AST_TSET_BIT: assert property (@(posedge clk) disable iff (rst)
    $past(in_vld && (in_op == OP_TSET) && !in_word) |-> res_q[LO_W-1]); // R8
  AST_BYTE_HIGH_KEPT: assert property (@(posedge clk) disable iff (rst)
    $past(in_vld && !in_word && (in_op >= OP_NEG) && (in_op <= OP_LAST))
      |-> (res_q[DATA_W-1:LO_W] == $past(dst_in[DATA_W-1:LO_W]))); // R11
endmodule

// File: tb/bw_unary_alu_bench.sv
module bw_unary_alu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [3:0]  in_op = '0;
  logic        in_word = 1'b0;
  logic [15:0] dst_in = '0;
  logic [15:0] src_in = '0;
  logic [15:0] res_q;
  logic        res_we, flag_n, flag_z, err;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  logic [15:0] m_res = '0;
  logic        m_n = 1'b0;
  logic        m_z = 1'b0;

  bw_unary_alu u_bw_unary_alu (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op), .in_word(in_word),
    .dst_in(dst_in), .src_in(src_in), .res_q(res_q), .res_we(res_we),
    .flag_n(flag_n), .flag_z(flag_z), .err(err)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired act=%0d exp<=150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op, input logic lg);
    if (!lg) return "R13";
    case (op)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4: return "R7";
      4'd5: return "R8";
      4'd6, 4'd7, 4'd8: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic run_op(input logic [3:0] op, input logic w,
                        input logic [15:0] d, input logic [15:0] s);
    logic        lg;
    logic [15:0] er;
    logic [15:0] fv;
    logic        fw;
    logic [7:0]  lo;
    string       t;
    lg = (op < 4'd10) && !(w && (op == 4'd0 || op == 4'd1 || op == 4'd5));
    case (op)
      4'd3: lo = 8'd0 - d[7:0];
      4'd4: lo = 8'h00;
      4'd6: lo = d[7:0] & s[7:0];
      4'd7: lo = d[7:0] | s[7:0];
      4'd8: lo = d[7:0] ^ s[7:0];
      4'd9: lo = ~d[7:0];
      default: lo = d[7:0];
    endcase
    case (op)
      4'd0: er = {{8{d[7]}}, d[7:0]};
      4'd1: er = {8'h00, d[7:0]};
      4'd3: er = w ? 16'(17'h10000 - {1'b0, d}) : {d[15:8], lo};
      4'd4: er = w ? 16'h0000 : {d[15:8], lo};
      4'd5: er = {d[15:8], 1'b1, d[6:0]};
      4'd6: er = w ? (d & s) : {d[15:8], lo};
      4'd7: er = w ? (d | s) : {d[15:8], lo};
      4'd8: er = w ? (d ^ s) : {d[15:8], lo};
      4'd9: er = w ? (d ^ 16'hFFFF) : {d[15:8], lo};
      default: er = d;
    endcase
    fv = (op == 4'd2 || op == 4'd5) ? d : er;
    fw = w && !(op == 4'd0 || op == 4'd1);
    if (lg) begin
      if (op != 4'd2) m_res = er;
      m_n = fw ? fv[15] : fv[7];
      m_z = fw ? (fv == 16'h0) : (fv[7:0] == 8'h0);
    end
    t = tag_of(op, lg);
    in_vld = 1'b1; in_op = op; in_word = w; dst_in = d; src_in = s;
    @(posedge clk); @(negedge clk);
    chk({t, (!w && lg) ? " R11 result" : " result"}, res_q, m_res);
    chk({t, " we"}, {15'd0, res_we}, {15'd0, lg && op != 4'd2});
    chk({t, " R12 N"}, {15'd0, flag_n}, {15'd0, m_n});
    chk({t, " R12 Z"}, {15'd0, flag_z}, {15'd0, m_z});
    chk({t, " err"}, {15'd0, err}, {15'd0, !lg});
    in_vld = 1'b0; dst_in = ~d; src_in = ~s; in_op = 4'd3;
    @(posedge clk); @(negedge clk);
    chk("R2 idle we", {15'd0, res_we}, 16'd0);
    chk("R2 idle err", {15'd0, err}, 16'd0);
    chk("R2 idle hold", {res_q[15:0]}, m_res);
    chk("R2 idle flags", {14'd0, flag_n, flag_z}, {14'd0, m_n, m_z});
  endtask

  logic [15:0] pats [10] = '{16'h0000, 16'h0080, 16'h007F, 16'h00FF, 16'hFF00,
                             16'h8000, 16'h1234, 16'hFFFF, 16'hA5C3, 16'h0100};

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset res", res_q, 16'h0);
    chk("R1 reset ctl", {12'd0, res_we, flag_n, flag_z, err}, 16'h0);
    rst = 1'b0;
    for (int op = 0; op < 16; op++)
      for (int w = 0; w < 2; w++)
        for (int i = 0; i < 10; i++)
          for (int j = 0; j < 10; j++)
            run_op(4'(op), 1'(w), pats[i], pats[(i + j) % 10] ^ {8'h00, 8'(j * 37)});
    run_op(4'd9, 1'b1, 16'h0F0F, 16'h0);
    in_vld = 1'b1; in_op = 4'd7; in_word = 1'b1; dst_in = 16'hFFFF; src_in = 16'h0;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 mid reset res", res_q, 16'h0);
    chk("R1 mid reset ctl", {12'd0, res_we, flag_n, flag_z, err}, 16'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule